// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block turns up to eight (six by default) asynchronous interrupt pins into clean request lines, one line per channel, for a downstream interrupt controller. Every pin is first brought into the clock domain. A small per-channel state machine then watches the synchronised value for the trigger that software has chosen. The trigger can be a rising edge, a falling edge, either edge, a high level or a low level. The result is held in a pending bit, and that bit is gated by an enable bit.

Software reaches the unit over a simple 32-bit register bus with a write strobe and a combinational read path. There are four word registers. The trigger-mode word packs one 4-bit code per channel. A spare word is plain storage. The pending word is cleared by writing zero to a bit. The enable word gates the requests. Drivers usually program each channel to low-level trigger when they bring it up.

Each channel machine has three states:
- `CH_IDLE`: nothing is pending.
- `CH_LATCHED`: an edge has been captured and is held.
- `CH_LEVEL`: the pending bit tracks an active level.

Its transitions are:
- IDLE→LATCHED on a selected edge.
- IDLE→LEVEL when the selected level is active and the channel is enabled.
- LATCHED→LATCHED on a new selected edge, or while the mode stays an edge mode and no clear arrives.
- LATCHED→IDLE on a clear without a new edge, or when the mode leaves the edge group.
- LEVEL→LATCHED when an edge mode now applies and its edge is seen.
- LEVEL→LEVEL while the level stays active, the channel stays enabled and no clear arrives.
- LEVEL→IDLE otherwise.

Top module: `exti_unit`

## Requirements
- R1: After reset the trigger-mode, spare, pending and enable words all read zero and every request output is low.
- R2: The register bus decodes a byte address. Offset 0x0 is the trigger-mode word, with channel i in bits [4i+3:4i]. Offset 0x4 is a 32-bit read/write spare word. Offset 0x8 is the pending word, with bit i for channel i. Offset 0xC is the enable word, with bit i for channel i. Reads are combinational. Unimplemented bits read zero. A write with a non-zero address bit 1 or bit 0 is ignored.
- R3: Trigger code 1 (rising edge) sets the channel's pending bit on a 0→1 pin change. The bit reads 0 at the second falling clock edge after the pin change and reads 1 at the third.
- R4: Trigger code 2 (falling edge) sets the pending bit on a 1→0 pin change, with the same latency as R3.
- R5: Trigger code 3 (both edges) sets the pending bit on any pin change, with the same latency as R3.
- R6: Trigger code 5 (high level) makes the pending bit 1 while the pin is high and the channel is enabled. The bit drops at the second clock edge after the enable bit is cleared, and three edges after the pin goes low.
- R7: Trigger code 6 (low level) makes the pending bit 1 while the pin is low and the channel is enabled.
- R8: Codes 0, 4 and 7 to 15 never set a pending bit, whatever the pin does.
- R9: In the edge modes a pending bit holds until 0 is written to its bit at offset 0x8. Writing 1 there leaves it unchanged. A selected edge that is detected in the same cycle as the clear keeps the bit set.
- R10: A request output is high exactly when its pending bit and its enable bit are both 1. An edge is latched even while the channel is disabled, so setting the enable bit afterwards raises the request right after that write.
- R11: Clearing a level-mode pending bit while the level is still active drops the bit for one cycle; it is set again at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_CH | Asynchronous external interrupt pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | N_CH | Per-channel request to the interrupt controller |

## Verification
A pin change becomes visible in the pending word at the third rising edge after it. Two synchroniser flops and the state register lie on that path. The bench therefore changes pins on a falling edge and reads on falling edges counted from that point. The latency case reads at both the second and the third falling edge. Register writes take effect at the edge inside the write task, and reads are combinational, so results that depend only on a write are sampled at the falling edge right after it. A cleared level-mode bit is read there and again one edge later. The case where a clear meets an edge places the write strobe in the one cycle in which the synchronised edge is visible.

// File: rtl/exti_pkg.sv
package exti_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;
    localparam int CODE_W = 4;

    localparam logic [1:0] SLOT_MODE  = 2'd0;
    localparam logic [1:0] SLOT_SPARE = 2'd1;
    localparam logic [1:0] SLOT_PEND  = 2'd2;
    localparam logic [1:0] SLOT_EN    = 2'd3;

    typedef enum logic [CODE_W-1:0] {
        TRIG_NONE = 4'd0,
        TRIG_RISE = 4'd1,
        TRIG_FALL = 4'd2,
        TRIG_BOTH = 4'd3,
        TRIG_HIGH = 4'd5,
        TRIG_LOW  = 4'd6
    } trig_t;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_LATCHED = 2'd1,
        CH_LEVEL   = 2'd2
    } ch_state_t;

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] meta_q;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[b] <= 1'b0;
                    cur_o[b]  <= 1'b0;
                    prev_o[b] <= 1'b0;
                end else begin
                    meta_q[b] <= pin_i[b];
                    cur_o[b]  <= meta_q[b];
                    prev_o[b] <= cur_o[b];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/exti_chan.sv
module exti_chan
    import exti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mode_i,
    input  logic              en_i,
    input  logic              clr_i,
    input  logic              cur_i,
    input  logic              prev_i,
    output logic              pend_o
);

    ch_state_t state_q, state_d;
    logic edge_mode, edge_hit, lvl_mode, lvl_on;
    logic set_edge, lvl_act;

    always_comb begin
        edge_mode = 1'b0;
        edge_hit  = 1'b0;
        lvl_mode  = 1'b0;
        lvl_on    = 1'b0;
        unique case (mode_i)
            TRIG_RISE: begin edge_mode = 1'b1; edge_hit = cur_i & ~prev_i; end
            TRIG_FALL: begin edge_mode = 1'b1; edge_hit = ~cur_i & prev_i; end
            TRIG_BOTH: begin edge_mode = 1'b1; edge_hit = cur_i ^ prev_i;  end
            TRIG_HIGH: begin lvl_mode = 1'b1;  lvl_on = cur_i;             end
            TRIG_LOW:  begin lvl_mode = 1'b1;  lvl_on = ~cur_i;            end
            default:   begin edge_mode = 1'b0;                             end
        endcase
        set_edge = edge_mode & edge_hit;
        lvl_act  = lvl_mode & lvl_on & en_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (set_edge)     state_d = CH_LATCHED;
                else if (lvl_act) state_d = CH_LEVEL;
            end
            CH_LATCHED: begin
                if (set_edge)                     state_d = CH_LATCHED;
                else if (!edge_mode || clr_i)     state_d = CH_IDLE;
            end
            CH_LEVEL: begin
                if (set_edge)                     state_d = CH_LATCHED;
                else if (lvl_act && !clr_i)       state_d = CH_LEVEL;
                else                              state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q != CH_IDLE);
    end

endmodule

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
#(
    parameter int N_CH = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [BUS_W-1:0]       wdata_i,
    input  logic [N_CH-1:0]        pend_i,
    output logic [BUS_W-1:0]       rdata_o,
    output logic [CODE_W*N_CH-1:0] mode_o,
    output logic [N_CH-1:0]        en_o,
    output logic [N_CH-1:0]        clr_o
);

    localparam int MODE_W = CODE_W * N_CH;

    logic [BUS_W-1:0] spare_q;
    logic [1:0]       slot;
    logic             aligned;

    assign slot    = addr_i[3:2];
    assign aligned = (addr_i[1:0] == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o  <= '0;
            spare_q <= '0;
            en_o    <= '0;
        end else if (we_i && aligned) begin
            unique case (slot)
                SLOT_MODE:  mode_o  <= wdata_i[MODE_W-1:0];
                SLOT_SPARE: spare_q <= wdata_i;
                SLOT_EN:    en_o    <= wdata_i[N_CH-1:0];
                default:    spare_q <= spare_q;
            endcase
        end
    end

    always_comb begin
        clr_o = (we_i && aligned && slot == SLOT_PEND) ? ~wdata_i[N_CH-1:0] : '0;
    end

    always_comb begin
        unique case (slot)
            SLOT_MODE:  rdata_o = BUS_W'(mode_o);
            SLOT_SPARE: rdata_o = spare_q;
            SLOT_PEND:  rdata_o = BUS_W'(pend_i);
            default:    rdata_o = BUS_W'(en_o);
        endcase
    end

endmodule

// File: rtl/exti_unit.sv
module exti_unit
    import exti_pkg::*;
#(
    parameter int N_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   pin_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [N_CH-1:0]   irq_o
);

    localparam int MODE_W = CODE_W * N_CH;

    logic [N_CH-1:0]   pin_s, pin_p;
    logic [N_CH-1:0]   pend, en_q, clr;
    logic [MODE_W-1:0] cfg_q;

    exti_sync #(.WIDTH(N_CH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cur_o  (pin_s),
        .prev_o (pin_p)
    );

    exti_regs #(.N_CH(N_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .pend_i  (pend),
        .rdata_o (bus_rdata),
        .mode_o  (cfg_q),
        .en_o    (en_q),
        .clr_o   (clr)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            exti_chan u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .mode_i (cfg_q[CODE_W*c +: CODE_W]),
                .en_i   (en_q[c]),
                .clr_i  (clr[c]),
                .cur_i  (pin_s[c]),
                .prev_i (pin_p[c]),
                .pend_o (pend[c])
            );
        end
    endgenerate

    assign irq_o = pend & en_q;

endmodule

// File: rtl/exti_unit_chk.sv
module exti_unit_chk
    import exti_pkg::*;
#(
    parameter int N_CH = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [BUS_W-1:0]       bus_wdata,
    input logic [CODE_W*N_CH-1:0] cfg_q,
    input logic [N_CH-1:0]        en_q,
    input logic [N_CH-1:0]        pend_q,
    input logic [N_CH-1:0]        cur_q,
    input logic [N_CH-1:0]        prev_q
);

    function automatic logic is_edge(input logic [CODE_W-1:0] m);
        return (m == 4'd1) || (m == 4'd2) || (m == 4'd3);
    endfunction

    function automatic logic is_level(input logic [CODE_W-1:0] m);
        return (m == 4'd5) || (m == 4'd6);
    endfunction

    function automatic logic is_none(input logic [CODE_W-1:0] m);
        return !is_edge(m) && !is_level(m);
    endfunction

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_chk
            logic [CODE_W-1:0] m;
            logic              clr_hit;
            assign m       = cfg_q[CODE_W*c +: CODE_W];
            assign clr_hit = bus_we && (bus_addr == 4'h8) && !bus_wdata[c];

            p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (m == 4'd1 && cur_q[c] && !prev_q[c]) |=> pend_q[c]);

            p_fall_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (m == 4'd2 && !cur_q[c] && prev_q[c]) |=> pend_q[c]);

            p_none_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (is_none(m) && !pend_q[c]) |=> !pend_q[c]);

            p_edge_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[c] && is_edge(m) && is_edge($past(m)) && !clr_hit) |=> pend_q[c]);

            p_level_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (is_level(m) && is_level($past(m)) && !en_q[c]) |=> !pend_q[c]);
        end
    endgenerate

endmodule

bind exti_unit exti_unit_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cfg_q     (cfg_q),
    .en_q      (en_q),
    .pend_q    (pend),
    .cur_q     (pin_s),
    .prev_q    (pin_p)
);

// File: tb/exti_unit_tb.sv
`timescale 1ns/1ps
module exti_unit_tb;

    localparam int N = 6;
    localparam logic [3:0] A_MODE = 4'h0, A_SPARE = 4'h4, A_PEND = 4'h8, A_EN = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          we = 1'b0;
    logic [3:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  irq;
    int            n_chk = 0;
    int            n_bad = 0;
    logic [31:0]   rd;

    always #2.5 clk = ~clk;

    exti_unit #(.N_CH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_pin(input int c, input logic v);
        @(negedge clk);
        pins[c] = v;
    endtask

    function automatic logic exp_pend(input int mode, input logic o, input logic n, input logic en);
        case (mode)
            1: return !o && n;
            2: return o && !n;
            3: return o != n;
            5: return n && en;
            6: return !n && en;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=complete");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        wait_neg(4);
        rst_n = 1'b1;
        wait_neg(1);

        // R1 reset state
        rdreg(A_MODE, rd);  check("R1 mode", rd, 0);
        rdreg(A_SPARE, rd); check("R1 spare", rd, 0);
        rdreg(A_PEND, rd);  check("R1 pend", rd, 0);
        rdreg(A_EN, rd);    check("R1 en", rd, 0);
        check("R1 irq", 32'(irq), 0);

        // R2 map, unimplemented bits, misaligned write
        wr(A_MODE, 32'hFFFF_FFFF);
        rdreg(A_MODE, rd);  check("R2 mode width", rd, 32'h00FF_FFFF);
        wr(A_EN, 32'hFFFF_FFFF);
        rdreg(A_EN, rd);    check("R2 en width", rd, 32'h0000_003F);
        wr(A_SPARE, 32'hA5A5_1234);
        rdreg(A_SPARE, rd); check("R2 spare", rd, 32'hA5A5_1234);
        wr(4'h5, 32'h0);
        rdreg(A_SPARE, rd); check("R2 misaligned ignored", rd, 32'hA5A5_1234);
        wr(A_MODE, 0);
        wr(A_EN, 0);
        wr(A_PEND, 0);

        // R3 rising latency on ch0
        wr(A_MODE, 32'h1);
        wr(A_EN, 32'h1);
        wait_neg(4);
        set_pin(0, 1'b1);
        wait_neg(2);
        rdreg(A_PEND, rd);  check("R3 not yet", rd, 0);
        wait_neg(1);
        rdreg(A_PEND, rd);  check("R3 set", rd, 32'h1);
        check("R3 irq", 32'(irq), 32'h1);

        // R9 write one keeps, write zero clears
        wr(A_PEND, 32'h3F);
        rdreg(A_PEND, rd);  check("R9 write one keeps", rd, 32'h1);
        wr(A_PEND, 32'h3E);
        rdreg(A_PEND, rd);  check("R9 write zero clears", rd, 0);
        check("R10 irq off", 32'(irq), 0);

        // R4 falling on ch1
        wr(A_MODE, 32'h20);
        wr(A_EN, 32'h2);
        set_pin(1, 1'b1);
        wait_neg(4);
        wr(A_PEND, 0);
        rdreg(A_PEND, rd);  check("R4 rise ignored", rd, 0);
        set_pin(1, 1'b0);
        wait_neg(3);
        rdreg(A_PEND, rd);  check("R4 fall sets", rd, 32'h2);
        wr(A_PEND, 0);

        // R5 and R9 clear coinciding with edge, ch2 both edges
        wr(A_MODE, 32'h300);
        wr(A_EN, 32'h4);
        set_pin(2, 1'b1);
        wait_neg(3);
        rdreg(A_PEND, rd);  check("R5 rise sets", rd, 32'h4);
        @(negedge clk) pins[2] = 1'b0;
        @(negedge clk);
        @(negedge clk) begin we = 1'b1; addr = A_PEND; wdata = 0; end
        @(negedge clk) we = 1'b0;
        rdreg(A_PEND, rd);  check("R9 edge beats clear", rd, 32'h4);
        wait_neg(4);
        wr(A_PEND, 0);
        rdreg(A_PEND, rd);  check("R9 clear after", rd, 0);

        // R10 latched while disabled, then enable
        wr(A_MODE, 32'h1000);
        wr(A_EN, 0);
        set_pin(3, 1'b1);
        wait_neg(4);
        rdreg(A_PEND, rd);  check("R10 latched disabled", rd, 32'h8);
        check("R10 irq gated", 32'(irq), 0);
        wr(A_EN, 32'h8);
        check("R10 irq after enable", 32'(irq), 32'h8);
        wr(A_PEND, 0);

        // R6 high level on ch4
        wr(A_MODE, 32'h5_0000);
        wr(A_EN, 32'h10);
        set_pin(4, 1'b1);
        wait_neg(4);
        rdreg(A_PEND, rd);  check("R6 high sets", rd, 32'h10);
        wr(A_EN, 0);
        check("R6 irq off on disable", 32'(irq), 0);
        wait_neg(1);
        rdreg(A_PEND, rd);  check("R6 drops on disable", rd, 0);
        wr(A_EN, 32'h10);
        wait_neg(2);
        rdreg(A_PEND, rd);  check("R6 back on enable", rd, 32'h10);
        set_pin(4, 1'b0);
        wait_neg(3);
        rdreg(A_PEND, rd);  check("R6 drops on low pin", rd, 0);

        // R7 and R11 low level on ch5
        wr(A_MODE, 32'h60_0000);
        wr(A_EN, 32'h20);
        wait_neg(2);
        rdreg(A_PEND, rd);  check("R7 low sets", rd, 32'h20);
        wr(A_PEND, 0);
        rdreg(A_PEND, rd);  check("R11 dropped one cycle", rd, 0);
        wait_neg(1);
        rdreg(A_PEND, rd);  check("R11 set again", rd, 32'h20);
        set_pin(5, 1'b1);
        wait_neg(3);
        rdreg(A_PEND, rd);  check("R7 high pin clears", rd, 0);

        // R8 code 4 ignores pin
        wr(A_MODE, 32'h4);
        wr(A_EN, 32'h1);
        set_pin(0, 1'b0);
        wait_neg(4);
        set_pin(0, 1'b1);
        wait_neg(4);
        rdreg(A_PEND, rd);  check("R8 code4 quiet", rd, 0);

        // random trials over all channels and codes (R3-R8, R10)
        for (int t = 0; t < 48; t++) begin
            int c, mode, sel;
            logic en, o, n;
            logic e;
            c   = int'($urandom % N);
            sel = int'($urandom % 9);
            case (sel)
                0: mode = 0; 1: mode = 1; 2: mode = 2; 3: mode = 3;
                4: mode = 4; 5: mode = 5; 6: mode = 6; 7: mode = 7;
                default: mode = 15;
            endcase
            en = 1'($urandom % 2);
            o  = 1'($urandom % 2);
            n  = 1'($urandom % 2);
            wr(A_EN, 0);
            wr(A_MODE, 32'(mode) << (4 * c));
            @(negedge clk);
            pins = '0;
            pins[c] = o;
            wait_neg(4);
            wr(A_EN, 32'(en) << c);
            wr(A_PEND, 0);
            set_pin(c, n);
            wait_neg(4);
            e = exp_pend(mode, o, n, en);
            rdreg(A_PEND, rd);
            check($sformatf("R3-R8 rand mode %0d pend", mode), rd, 32'(e) << c);
            check("R10 rand irq", 32'(irq), 32'(e & en) << c);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule